// File: doc/BRIEF.md
# Video-Fetch Bus Glue

This block connects an 8-bit CPU with a Z80-style bus to a small home computer's ROM, RAM and display path. Each clock the CPU presents one bus cycle kind, an address, write data and one bit tapped from its refresh counter. The block returns read data in the same cycle. It steers memory writes into an internal RAM. It keeps a sync level that I/O accesses raise and lower, and it produces an interrupt request from the refresh counter.

The display picture comes from program fetches. When the CPU fetches an opcode from the upper half of memory and the RAM byte there has bit 6 clear, the byte goes to the video port with a one-cycle strobe. The CPU then receives a no-operation byte, so it runs through the display line without acting on it. Character lookup, pixel shifting and analogue output live elsewhere.

The RAM is `2**RAM_AW` bytes and aliases across the 16-bit address space. The ROM sits outside the block behind `rom_addr`/`rom_rdata` and takes the lowest `ROM_BYTES` addresses.

Top module: `vid_bus_glue`

## Requirements
- R1: Cycle kinds on `cpu_op` are encoded as 0 idle, 1 memory read, 2 opcode fetch, 3 memory write, 4 I/O read, 5 I/O write and 6 interrupt acknowledge. A synchronous active-high `rst` clears `sync_level` and `irq_req`.
- R2: An I/O write whose address low byte is 0xFF makes `sync_level` 0 from the next cycle.
- R3: An I/O read whose address low byte is 0xFE makes `sync_level` 1 from the next cycle. Any other cycle leaves `sync_level` unchanged.
- R4: During interrupt acknowledge, `cpu_rdata` is 0xFF in the same cycle. It is also 0xFF for idle, write and I/O cycles.
- R5: On every opcode fetch, `irq_req` becomes the inverse of `refresh_tap` from the next cycle. Other cycles leave it unchanged.
- R6: A memory read or fetch with address below `ROM_BYTES` (default 4096) returns `rom_rdata`, with `rom_addr` equal to the low address bits.
- R7: A memory read or fetch at or above `ROM_BYTES` returns the RAM byte at the address modulo `2**RAM_AW` (default 4096).
- R8: An opcode fetch from an address strictly above 0x8000 whose RAM byte has bit 6 clear sets `vid_valid` in that same cycle, with `vid_byte` equal to that byte, and returns 0x00 on `cpu_rdata`.
- R9: Data reads above 0x8000, fetches there of bytes with bit 6 set, and fetches at exactly 0x8000 return the RAM byte unchanged with `vid_valid` low.
- R10: A memory write stores `cpu_wdata` in RAM at the aliased address, even inside the ROM range. ROM-range reads still return ROM data, while the aliased location above the ROM returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 3 | Bus cycle kind |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| refresh_tap | input | 1 | Bit 6 of the CPU refresh counter |
| cpu_rdata | output | 8 | Data returned to the CPU |
| rom_addr | output | ROM_AW (12) | ROM address |
| rom_rdata | input | 8 | ROM data, combinational |
| vid_byte | output | 8 | Display byte taken from a fetch |
| vid_valid | output | 1 | One-cycle strobe for vid_byte |
| sync_level | output | 1 | Sync flag driven by I/O accesses |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
Read data, the NOP substitution and the video strobe are combinational, so they belong to the cycle that carries the bus access. The bench samples them one nanosecond after it drives the inputs, before the next rising edge. Sync, interrupt and RAM contents change at the edge that ends the access, so the reference model updates only after that edge and compares them one cycle later. A write followed by a read therefore sees the new byte on the read cycle directly after it.

// File: rtl/vid_glue_pkg.sv
package vid_glue_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE  = 3'd0,
        BUS_MRD   = 3'd1,
        BUS_FETCH = 3'd2,
        BUS_MWR   = 3'd3,
        BUS_IORD  = 3'd4,
        BUS_IOWR  = 3'd5,
        BUS_INTA  = 3'd6
    } bus_op_e;

    typedef enum logic [1:0] {
        SRC_FLOAT = 2'd0,
        SRC_ROM   = 2'd1,
        SRC_RAM   = 2'd2
    } data_src_e;

    typedef struct packed {
        data_src_e src;
        logic      ram_we;
        logic      steal_cand;
        logic      sync_set;
        logic      sync_clr;
        logic      irq_load;
    } cyc_dec_t;

    localparam logic [7:0] NOP_BYTE      = 8'h00;
    localparam logic [7:0] FLOAT_BYTE    = 8'hFF;
    localparam logic [7:0] SYNC_SET_PORT = 8'hFE;
    localparam logic [7:0] SYNC_CLR_PORT = 8'hFF;
    localparam int         VID_FLAG_BIT  = 6;

    // A fetched byte goes to the display when its flag bit is clear.
    function automatic logic vid_eligible(input logic [7:0] b);
        return !b[VID_FLAG_BIT];
    endfunction

endpackage

// File: rtl/glue_decode.sv
module glue_decode
    import vid_glue_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               ROM_BYTES = 4096,
    parameter logic [ADDR_W-1:0] VID_BASE = 16'h8000
) (
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output cyc_dec_t          dec
);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_BYTES);

    bus_op_e op_e;
    logic    in_rom;
    logic    upper;

    assign op_e   = bus_op_e'(op);
    assign in_rom = {1'b0, addr} < ROM_LIM;
    assign upper  = addr > VID_BASE;

    always_comb begin
        dec     = '0;
        dec.src = SRC_FLOAT;
        case (op_e)
            BUS_MRD: begin
                dec.src = in_rom ? SRC_ROM : SRC_RAM;
            end
            BUS_FETCH: begin
                dec.src        = in_rom ? SRC_ROM : SRC_RAM;
                dec.irq_load   = 1'b1;
                dec.steal_cand = !in_rom && upper;
            end
            BUS_MWR:  dec.ram_we   = 1'b1;
            BUS_IORD: dec.sync_set = (addr[7:0] == SYNC_SET_PORT);
            BUS_IOWR: dec.sync_clr = (addr[7:0] == SYNC_CLR_PORT);
            default:  ;
        endcase
    end
endmodule

// File: rtl/glue_ram.sv
module glue_ram #(
    parameter int RAM_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/glue_ctrl.sv
module glue_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic sync_set,
    input  logic sync_clr,
    input  logic irq_load,
    input  logic refresh_tap,
    output logic sync_q,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (sync_set)      sync_q <= 1'b1;
            else if (sync_clr) sync_q <= 1'b0;
            if (irq_load)      irq_q  <= !refresh_tap;
        end
    end
endmodule

// File: rtl/vid_bus_glue.sv
module vid_bus_glue
    import vid_glue_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                ROM_BYTES = 4096,
    parameter int                RAM_AW    = 12,
    parameter logic [ADDR_W-1:0] VID_BASE  = 16'h8000,
    localparam int               ROM_AW    = $clog2(ROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              refresh_tap,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_rdata,
    output logic [7:0]        vid_byte,
    output logic              vid_valid,
    output logic              sync_level,
    output logic              irq_req
);
    cyc_dec_t   dec;
    logic [7:0] ram_q;
    logic [7:0] base_data;
    logic       steal;

    glue_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_BYTES(ROM_BYTES),
        .VID_BASE (VID_BASE)
    ) u_dec (
        .op  (cpu_op),
        .addr(cpu_addr),
        .dec (dec)
    );

    glue_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk  (clk),
        .we   (dec.ram_we),
        .addr (cpu_addr[RAM_AW-1:0]),
        .wdata(cpu_wdata),
        .rdata(ram_q)
    );

    glue_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sync_set   (dec.sync_set),
        .sync_clr   (dec.sync_clr),
        .irq_load   (dec.irq_load),
        .refresh_tap(refresh_tap),
        .sync_q     (sync_level),
        .irq_q      (irq_req)
    );

    assign rom_addr = cpu_addr[ROM_AW-1:0];

    always_comb begin
        case (dec.src)
            SRC_ROM: base_data = rom_rdata;
            SRC_RAM: base_data = ram_q;
            default: base_data = FLOAT_BYTE;
        endcase
    end

    assign steal     = dec.steal_cand && vid_eligible(ram_q);
    assign cpu_rdata = steal ? NOP_BYTE : base_data;
    assign vid_valid = steal;
    assign vid_byte  = steal ? ram_q : 8'h00;
endmodule

// File: rtl/vid_glue_chk.sv
module vid_glue_chk
    import vid_glue_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VID_BASE = 16'h8000
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              refresh_tap,
    input logic [7:0]        cpu_rdata,
    input logic              vid_valid,
    input logic              sync_level,
    input logic              irq_req
);
    // R2
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == BUS_IOWR && cpu_addr[7:0] == 8'hFF) |=> !sync_level);

    // R3
    sync_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == BUS_IORD && cpu_addr[7:0] == 8'hFE) |=> sync_level);

    // R3
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !((cpu_op == BUS_IORD && cpu_addr[7:0] == 8'hFE) ||
          (cpu_op == BUS_IOWR && cpu_addr[7:0] == 8'hFF)) |=> $stable(sync_level));

    // R4
    inta_float_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == BUS_INTA) |-> (cpu_rdata == 8'hFF));

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_op == BUS_FETCH) |=> (irq_req == !$past(refresh_tap)));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_op != BUS_FETCH) |=> $stable(irq_req));

    // R8
    steal_nop_chk: assert property (@(posedge clk) disable iff (rst)
        vid_valid |-> (cpu_rdata == 8'h00 && cpu_op == BUS_FETCH && cpu_addr > VID_BASE));
endmodule

bind vid_bus_glue vid_glue_chk #(
    .ADDR_W  (ADDR_W),
    .VID_BASE(VID_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_op     (cpu_op),
    .cpu_addr   (cpu_addr),
    .refresh_tap(refresh_tap),
    .cpu_rdata  (cpu_rdata),
    .vid_valid  (vid_valid),
    .sync_level (sync_level),
    .irq_req    (irq_req)
);

// File: tb/sim_vid_bus_glue.sv
`timescale 1ns/1ps
module sim_vid_bus_glue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_op = 3'd0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        refresh_tap = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [11:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [7:0]  vid_byte;
    logic        vid_valid;
    logic        sync_level;
    logic        irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_ram [4096];
    logic       m_sync = 1'b0;
    logic       m_irq = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_f(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

    assign rom_rdata = rom_f(rom_addr);

    vid_bus_glue u0 (
        .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .refresh_tap(refresh_tap), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .vid_byte(vid_byte),
        .vid_valid(vid_valid), .sync_level(sync_level), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bus cycle: drive after the falling edge, check combinational results
    // and the registered state, then advance the model past the rising edge.
    task automatic cyc(input logic [2:0] op, input logic [15:0] a,
                       input logic [7:0] wd, input logic rb, input string note);
        logic [7:0] exp_d;
        logic       exp_v;
        logic [7:0] exp_b;
        string      tag;
        @(negedge clk);
        cpu_op = op; cpu_addr = a; cpu_wdata = wd; refresh_tap = rb;
        #1;
        exp_v = 1'b0; exp_b = 8'h00; exp_d = 8'hFF; tag = "R4";
        if (op == 3'd1 || op == 3'd2) begin
            if (a < 16'h1000) begin
                exp_d = rom_f(a[11:0]); tag = "R6";
            end else begin
                exp_d = m_ram[a[11:0]]; tag = (a > 16'h8000) ? "R9" : "R7";
                if (op == 3'd2 && a > 16'h8000 && !m_ram[a[11:0]][6]) begin
                    exp_v = 1'b1; exp_b = m_ram[a[11:0]]; exp_d = 8'h00; tag = "R8";
                end
            end
        end
        chk(tag, {note, " rdata"}, cpu_rdata, exp_d);
        chk(tag, {note, " vid_valid"}, {7'b0, vid_valid}, {7'b0, exp_v});
        if (exp_v) chk("R8", {note, " vid_byte"}, vid_byte, exp_b);
        if (op == 3'd1 || op == 3'd2) chk("R6", {note, " rom_addr"}, {4'b0, rom_addr[11:8]}, {4'b0, a[11:8]});
        chk("R3", {note, " sync"}, {7'b0, sync_level}, {7'b0, m_sync});
        chk("R5", {note, " irq"}, {7'b0, irq_req}, {7'b0, m_irq});
        @(posedge clk);
        // R2 R3 R5 R10 model update at the edge
        if (op == 3'd5 && a[7:0] == 8'hFF) m_sync = 1'b0;
        if (op == 3'd4 && a[7:0] == 8'hFE) m_sync = 1'b1;
        if (op == 3'd2) m_irq = !rb;
        if (op == 3'd3) m_ram[a[11:0]] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_op = 3'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sync = 1'b0; m_irq = 1'b0;
        #1;
        chk("R1", "reset sync", {7'b0, sync_level}, 8'h00);
        chk("R1", "reset irq", {7'b0, irq_req}, 8'h00);
        chk("R1", "reset vid_valid", {7'b0, vid_valid}, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        // R10 fill every RAM location through aliased upper addresses
        for (int i = 0; i < 4096; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + (i >> 5));
            @(negedge clk);
            cpu_op = 3'd3; cpu_addr = 16'h8000 | 16'(i); cpu_wdata = v;
            @(posedge clk);
            m_ram[i] = v;
        end
        // R5 interrupt from refresh tap
        cyc(3'd2, 16'h0100, 8'h0, 1'b0, "R5 fetch tap0");
        cyc(3'd1, 16'h0101, 8'h0, 1'b1, "R5 read hold");
        cyc(3'd2, 16'h0102, 8'h0, 1'b1, "R5 fetch tap1");
        cyc(3'd0, 16'h0000, 8'h0, 1'b0, "R5 idle");
        // R3 and R2 sync control
        cyc(3'd4, 16'h34FE, 8'h0, 1'b0, "R3 set");
        cyc(3'd4, 16'h00FD, 8'h0, 1'b0, "R3 other port");
        cyc(3'd5, 16'h00FE, 8'h0, 1'b0, "R2 wrong port");
        cyc(3'd5, 16'h12FF, 8'h0, 1'b0, "R2 clear");
        cyc(3'd4, 16'hFFFF, 8'h0, 1'b0, "R3 read of FF");
        cyc(3'd0, 16'h0000, 8'h0, 1'b0, "R2 after");
        // R4
        cyc(3'd6, 16'h1234, 8'h0, 1'b0, "R4 inta");
        // R6 R7 boundary
        cyc(3'd1, 16'h0FFF, 8'h0, 1'b0, "R6 last rom");
        cyc(3'd1, 16'h1000, 8'h0, 1'b0, "R7 first ram");
        // R10 write in ROM range
        cyc(3'd3, 16'h0010, 8'h5A, 1'b0, "R10 write rom range");
        cyc(3'd1, 16'h0010, 8'h0, 1'b0, "R10 rom still visible");
        cyc(3'd1, 16'h1010, 8'h0, 1'b0, "R10 alias");
        // R8 R9 display stealing
        cyc(3'd3, 16'h8001, 8'h23, 1'b0, "R8 prep");
        cyc(3'd2, 16'h8001, 8'h0, 1'b1, "R8 steal");
        cyc(3'd1, 16'h8001, 8'h0, 1'b0, "R9 data read");
        cyc(3'd3, 16'h8000, 8'h11, 1'b0, "R9 prep base");
        cyc(3'd2, 16'h8000, 8'h0, 1'b0, "R9 fetch at base");
        cyc(3'd3, 16'h8002, 8'h47, 1'b0, "R9 prep flag");
        cyc(3'd2, 16'h8002, 8'h0, 1'b0, "R9 flag set");
        cyc(3'd3, 16'hFFFF, 8'h3F, 1'b0, "R8 prep top");
        cyc(3'd2, 16'hFFFF, 8'h0, 1'b0, "R8 top");
        cyc(3'd2, 16'h7FFF, 8'h0, 1'b1, "R7 below region");
        // R1 reset from a set state
        cyc(3'd4, 16'h00FE, 8'h0, 1'b0, "R1 set sync");
        cyc(3'd2, 16'h0000, 8'h0, 1'b0, "R1 set irq");
        do_reset();
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  op;
            logic [15:0] a;
            op = 3'($urandom_range(0, 6));
            a  = 16'($urandom);
            if (op == 3'd4 || op == 3'd5)
                a[7:0] = ($urandom_range(0, 2) == 0) ? 8'hFE :
                         ($urandom_range(0, 1) == 0) ? 8'hFF : a[7:0];
            cyc(op, a, 8'($urandom), 1'($urandom), "mix");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule